// File: doc/BRIEF.md
# Single-Cycle 32-bit Core with Compare-and-Jump-to-Register

This block is a single-cycle processor for a small integer subset: register-register add, subtract, and, or and set-less-than, plus load word, store word, branch-if-equal, add-immediate and an absolute jump. One extra instruction is added. It compares a register against a sign-extended immediate. When the register is the smaller of the two, it redirects the program counter to the value held in a second register. Every instruction fetches, decodes, executes, accesses memory and writes back within one clock cycle.

The block holds a 32-entry register file, an ALU with a fixed operation set, a main decoder, an ALU-function decoder, next-PC selection and two word-addressed arrays for instructions and data. A separate signed comparator resolves the new instruction, so the ALU operation set stays the same. A load port fills the instruction array, normally while reset is held. The current PC, each register write request and each store are visible on output ports. Through these ports an environment follows execution and checks results.

Top module: `mcore_top`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `pc_o` equals 0x00400000.
- R2: An instruction that does not redirect control is followed by PC+4, and `pc_o` always stays word aligned.
- R3: Opcode 000000 writes register field [15:11] with rs+rt (funct 100000), rs−rt (100010), rs AND rt (100100), rs OR rt (100101) or the signed set-less-than of rs and rt (101010, result 0 or 1).
- R4: Opcode 001000 writes register field [20:16] with rs + {16{imm[15]}, imm}.
- R5: Opcode 101011 stores rt at byte address rs+SignExt(imm) and shows the store on the `st_*` ports. Opcode 100011 loads the word at that address into rt.
- R6: Register 0 always reads as zero. A write to it is discarded.
- R7: Opcode 000100 with rs equal to rt sets the next PC to PC+4+(SignExt(imm)<<2). Otherwise the next PC is PC+4.
- R8: Opcode 000010 sets the next PC to {PC+4[31:28], instr[25:0], 2'b00}.
- R9: Opcode 111111 (rs in [25:21], rt in [20:16], imm in [15:0]) sets the next PC to the value of rt when rs, read as signed, is less than SignExt(imm). Otherwise the next PC is PC+4. Negative immediates are included.
- R10: Opcode 111111 requests no register write and no store.
- R11: `wb_en_o`, `wb_idx_o` and `wb_data_o` show the register write that the current instruction requests.
- R12: An opcode outside the listed set writes nothing and is followed by PC+4.
- R13: `prog_we` writes `prog_data` into instruction word `prog_addr` on a rising clock edge. Word k is fetched at PC 0x00400000+4k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_we | input | 1 | Instruction array write enable |
| prog_addr | input | 6 | Instruction word index to write |
| prog_data | input | 32 | Instruction word to write |
| pc_o | output | 32 | Current program counter |
| wb_en_o | output | 1 | Current instruction requests a register write |
| wb_idx_o | output | 5 | Destination register index |
| wb_data_o | output | 32 | Value to be written |
| st_en_o | output | 1 | Current instruction stores a word |
| st_addr_o | output | 32 | Store byte address |
| st_data_o | output | 32 | Store data |

## Verification
The bench builds the core with its default parameters: reset PC 0x00400000 and 64-word instruction and data arrays. These sizes hold a 50-word program that reaches every opcode, including a load that reads back its own earlier store. Because the PC starts at 0x00400000, a jump target has to be assembled in a register by repeated doubling. This path exercises the add-immediate and add paths with large values before the compare-and-jump instruction uses that register. The compare-and-jump instruction is run with a smaller operand, an equal operand, and negative immediates on both the taken and the not-taken side, and the PC is checked after each one.

// File: rtl/mcore_pkg.sv
package mcore_pkg;
  localparam int XLEN = 32;

  localparam logic [5:0] OP_RTYPE = 6'b000000;
  localparam logic [5:0] OP_LW    = 6'b100011;
  localparam logic [5:0] OP_SW    = 6'b101011;
  localparam logic [5:0] OP_BEQ   = 6'b000100;
  localparam logic [5:0] OP_ADDI  = 6'b001000;
  localparam logic [5:0] OP_J     = 6'b000010;
  localparam logic [5:0] OP_JRLT  = 6'b111111;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_SLT = 6'b101010;

  typedef enum logic [2:0] {ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT} alu_op_e;

  typedef struct packed {
    logic       reg_write;
    logic       reg_dst;
    logic       alu_src;
    logic       branch;
    logic       mem_write;
    logic       mem_to_reg;
    logic       jump;
    logic       reg_jump;
    logic [1:0] alu_sel;
  } ctrl_t;

  function automatic logic [31:0] sext16(input logic [15:0] imm);
    return {{16{imm[15]}}, imm};
  endfunction

  function automatic logic [31:0] br_target(input logic [31:0] pc4, input logic [15:0] imm);
    return pc4 + {{14{imm[15]}}, imm, 2'b00};
  endfunction

  function automatic logic [31:0] jmp_target(input logic [3:0] pc4_hi, input logic [25:0] idx);
    return {pc4_hi, idx, 2'b00};
  endfunction

  function automatic logic lt_signed(input logic [31:0] a, input logic [31:0] b);
    return $signed(a) < $signed(b);
  endfunction
endpackage

// File: rtl/mcore_main_dec.sv
module mcore_main_dec
  import mcore_pkg::*;
(
  input  logic [5:0] opcode,
  output ctrl_t      ctrl
);
  always_comb begin
    ctrl = '0;
    case (opcode)
      OP_RTYPE: begin
        ctrl.reg_write = 1'b1;
        ctrl.reg_dst   = 1'b1;
        ctrl.alu_sel   = 2'b10;
      end
      OP_LW: begin
        ctrl.reg_write  = 1'b1;
        ctrl.alu_src    = 1'b1;
        ctrl.mem_to_reg = 1'b1;
      end
      OP_SW: begin
        ctrl.alu_src   = 1'b1;
        ctrl.mem_write = 1'b1;
      end
      OP_BEQ: begin
        ctrl.branch  = 1'b1;
        ctrl.alu_sel = 2'b01;
      end
      OP_ADDI: begin
        ctrl.reg_write = 1'b1;
        ctrl.alu_src   = 1'b1;
      end
      OP_J:    ctrl.jump     = 1'b1;
      OP_JRLT: ctrl.reg_jump = 1'b1;
      default: ctrl = '0;
    endcase
  end
endmodule

// File: rtl/mcore_alu_dec.sv
module mcore_alu_dec
  import mcore_pkg::*;
(
  input  logic [1:0] alu_sel,
  input  logic [5:0] funct,
  output alu_op_e    op
);
  always_comb begin
    op = ALU_ADD;
    case (alu_sel)
      2'b01: op = ALU_SUB;
      2'b10: begin
        case (funct)
          FN_SUB:  op = ALU_SUB;
          FN_AND:  op = ALU_AND;
          FN_OR:   op = ALU_OR;
          FN_SLT:  op = ALU_SLT;
          FN_ADD:  op = ALU_ADD;
          default: op = ALU_ADD;
        endcase
      end
      default: op = ALU_ADD;
    endcase
  end
endmodule

// File: rtl/mcore_alu.sv
module mcore_alu
  import mcore_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] y,
  output logic         zero
);
  always_comb begin
    case (op)
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = a + b;
    endcase
  end

  assign zero = (y == '0);

  // R3
  slt_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == ALU_SLT) |-> (y[W-1:1] == '0));
endmodule

// File: rtl/mcore_regfile.sv
module mcore_regfile #(
  parameter  int NREG = 32,
  parameter  int W    = 32,
  localparam int AW   = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ra1,
  input  logic [AW-1:0] ra2,
  output logic [W-1:0]  rd1,
  output logic [W-1:0]  rd2,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd
);
  logic [W-1:0] regs [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we && (wa != '0)) begin
      regs[wa] <= wd;
    end
  end

  assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
  assign rd2 = (ra2 == '0) ? '0 : regs[ra2];

  // R6
  zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    regs[0] == '0);
endmodule

// File: rtl/mcore_top.sv
module mcore_top
  import mcore_pkg::*;
#(
  parameter  logic [31:0] RESET_PC   = 32'h0040_0000,
  parameter  int          IMEM_WORDS = 64,
  parameter  int          DMEM_WORDS = 64,
  localparam int          IAW        = $clog2(IMEM_WORDS),
  localparam int          DAW        = $clog2(DMEM_WORDS)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           prog_we,
  input  logic [IAW-1:0] prog_addr,
  input  logic [31:0]    prog_data,
  output logic [31:0]    pc_o,
  output logic           wb_en_o,
  output logic [4:0]     wb_idx_o,
  output logic [31:0]    wb_data_o,
  output logic           st_en_o,
  output logic [31:0]    st_addr_o,
  output logic [31:0]    st_data_o
);
  logic [31:0] pc_q, pc_next, pc4, pc_off, instr;
  logic [31:0] imem [IMEM_WORDS];
  logic [31:0] dmem [DMEM_WORDS];

  always_ff @(posedge clk) begin
    if (prog_we) imem[prog_addr] <= prog_data;
  end

  assign pc_off = pc_q - RESET_PC;
  assign instr  = imem[pc_off[IAW+1:2]];
  assign pc4    = pc_q + 32'd4;

  logic [5:0]  f_op, f_fn;
  logic [4:0]  f_rs, f_rt, f_rd;
  logic [15:0] f_imm;
  logic [25:0] f_idx;
  assign f_op  = instr[31:26];
  assign f_rs  = instr[25:21];
  assign f_rt  = instr[20:16];
  assign f_rd  = instr[15:11];
  assign f_fn  = instr[5:0];
  assign f_imm = instr[15:0];
  assign f_idx = instr[25:0];

  ctrl_t   ctrl;
  alu_op_e alu_op;

  mcore_main_dec u_mdec (.opcode(f_op), .ctrl(ctrl));
  mcore_alu_dec  u_adec (.alu_sel(ctrl.alu_sel), .funct(f_fn), .op(alu_op));

  logic [31:0] rs1_val, rs2_val, imm_x, alu_b, alu_y, ld_data, wr_data;
  logic [4:0]  wr_idx;
  logic        alu_zero;

  assign imm_x   = sext16(f_imm);
  assign alu_b   = ctrl.alu_src ? imm_x : rs2_val;
  assign wr_idx  = ctrl.reg_dst ? f_rd : f_rt;
  assign ld_data = dmem[alu_y[DAW+1:2]];
  assign wr_data = ctrl.mem_to_reg ? ld_data : alu_y;

  mcore_regfile #(.NREG(32), .W(32)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .ra1(f_rs), .ra2(f_rt), .rd1(rs1_val), .rd2(rs2_val),
    .we(ctrl.reg_write), .wa(wr_idx), .wd(wr_data)
  );

  mcore_alu #(.W(32)) u_alu (
    .clk(clk), .rst_n(rst_n),
    .a(rs1_val), .b(alu_b), .op(alu_op), .y(alu_y), .zero(alu_zero)
  );

  always_ff @(posedge clk) begin
    if (ctrl.mem_write) dmem[alu_y[DAW+1:2]] <= rs2_val;
  end

  // Control-transfer events, resolved beside the ALU
  logic br_taken, j_taken, rj_taken;
  assign br_taken = ctrl.branch & alu_zero;
  assign j_taken  = ctrl.jump;
  assign rj_taken = ctrl.reg_jump & lt_signed(rs1_val, imm_x);

  always_comb begin
    if (j_taken)       pc_next = jmp_target(pc4[31:28], f_idx);
    else if (rj_taken) pc_next = rs2_val;
    else if (br_taken) pc_next = br_target(pc4, f_imm);
    else               pc_next = pc4;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= RESET_PC;
    else        pc_q <= pc_next;
  end

  assign pc_o      = pc_q;
  assign wb_en_o   = ctrl.reg_write;
  assign wb_idx_o  = wr_idx;
  assign wb_data_o = wr_data;
  assign st_en_o   = ctrl.mem_write;
  assign st_addr_o = alu_y;
  assign st_data_o = rs2_val;

  logic unused_bits;
  assign unused_bits = ^{instr[10:6], pc_off[31:IAW+2], pc_off[1:0]};

  // R2
  pc_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_q[1:0] == 2'b00);

  // R2
  pc_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(br_taken || j_taken || rj_taken) |=> (pc_q == $past(pc_q) + 32'd4));

  // R9
  rj_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rj_taken |=> (pc_q == $past(rs2_val)));

  // R10
  rj_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.reg_jump |-> (!ctrl.reg_write && !ctrl.mem_write));
endmodule

// File: tb/tb_mcore_top.sv
module tb_mcore_top;
  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] BASE       = 32'h0040_0000;
  localparam int          NPROG      = 50;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        prog_we = 1'b0;
  logic [5:0]  prog_addr = '0;
  logic [31:0] prog_data = '0;
  logic [31:0] pc_o, wb_data_o, st_addr_o, st_data_o;
  logic        wb_en_o, st_en_o;
  logic [4:0]  wb_idx_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  bit marker_hit = 1'b0;
  logic [31:0] prog [NPROG];

  always #(CLK_PERIOD/2) clk = ~clk;

  mcore_top dut (
    .clk(clk), .rst_n(rst_n), .prog_we(prog_we), .prog_addr(prog_addr),
    .prog_data(prog_data), .pc_o(pc_o), .wb_en_o(wb_en_o), .wb_idx_o(wb_idx_o),
    .wb_data_o(wb_data_o), .st_en_o(st_en_o), .st_addr_o(st_addr_o), .st_data_o(st_data_o)
  );

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
    return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'b0, fn};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction
  function automatic logic [31:0] enc_j(int word_idx);
    logic [31:0] a = BASE + 32'(4 * word_idx);
    return {6'b000010, a[27:2]};
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic at(int idx, string tag);
    logic [31:0] e = BASE + 32'(4 * idx);
    chk(pc_o === e, tag, pc_o, e);
  endtask

  task automatic wb(int r, logic [31:0] v, string tag);
    chk(wb_en_o === 1'b1 && wb_idx_o === 5'(r) && wb_data_o === v, tag, wb_data_o, v);
  endtask

  task automatic nowb(string tag);
    chk(wb_en_o === 1'b0 && st_en_o === 1'b0, tag, {30'b0, wb_en_o, st_en_o}, 32'h0);
  endtask

  task automatic adv();
    @(negedge clk);
  endtask

  always @(negedge clk) if (rst_n && wb_en_o && wb_idx_o == 5'd12) marker_hit = 1'b1;

  task automatic build_program();
    for (int i = 0; i < NPROG; i++) prog[i] = enc_i(6'b001000, 0, 12, 16'd1);
    prog[0]  = enc_i(6'b001000, 0, 1, 16'd5);
    prog[1]  = enc_i(6'b001000, 0, 2, 16'hFFFD);
    prog[2]  = enc_r(1, 2, 3, 6'b100000);
    prog[3]  = enc_r(1, 2, 4, 6'b100010);
    prog[4]  = enc_r(1, 2, 5, 6'b100100);
    prog[5]  = enc_r(1, 2, 6, 6'b100101);
    prog[6]  = enc_r(2, 1, 7, 6'b101010);
    prog[7]  = enc_i(6'b001000, 0, 0, 16'd7);
    prog[8]  = enc_r(0, 0, 8, 6'b100000);
    prog[9]  = enc_i(6'b101011, 0, 1, 16'd8);
    prog[10] = enc_i(6'b100011, 0, 9, 16'd8);
    prog[11] = enc_i(6'b001000, 0, 10, 16'h4000);
    for (int k = 12; k < 20; k++) prog[k] = enc_r(10, 10, 10, 6'b100000);
    prog[20] = enc_i(6'b001000, 10, 11, 16'd120);
    prog[21] = enc_i(6'b111111, 1, 11, 16'd6);
    prog[30] = enc_i(6'b111111, 1, 11, 16'd5);
    prog[31] = enc_i(6'b111111, 2, 11, 16'hFFFC);
    prog[32] = enc_i(6'b001000, 10, 13, 16'd160);
    prog[33] = enc_i(6'b111111, 2, 13, 16'hFFFE);
    prog[40] = enc_i(6'b000100, 1, 2, 16'd5);
    prog[41] = enc_i(6'b000100, 1, 1, 16'd2);
    prog[44] = enc_j(47);
    prog[47] = enc_r(1, 2, 14, 6'b101010);
    prog[48] = enc_i(6'b111110, 1, 12, 16'd1);
    prog[49] = enc_j(49);
  endtask

  task automatic t_load_and_reset();
    build_program();
    for (int i = 0; i < NPROG; i++) begin
      @(negedge clk);
      prog_we = 1'b1; prog_addr = 6'(i); prog_data = prog[i];
    end
    @(negedge clk);
    prog_we = 1'b0;
    // R1: reset PC; R13: word 0 fetched at the reset PC
    at(0, "R1 pc during reset");
    wb(1, 32'd0 + 32'd5, "R13 word 0 visible at reset PC");
    rst_n = 1'b1;
    at(0, "R1 pc after release");
  endtask

  task automatic t_alu();
    wb(1, 32'd5, "R4 addi positive"); adv();
    at(1, "R2 pc+4"); wb(2, 32'hFFFF_FFFD, "R4 addi negative"); adv();
    wb(3, 32'd2, "R3 add"); adv();
    wb(4, 32'd8, "R3 sub"); adv();
    wb(5, 32'd5, "R3 and"); adv();
    wb(6, 32'hFFFF_FFFD, "R3 or"); adv();
    wb(7, 32'd1, "R3 slt signed"); adv();
    at(7, "R11 pc"); chk(wb_idx_o === 5'd0 && wb_data_o === 32'd7, "R11 write request to r0", wb_data_o, 32'd7); adv();
    wb(8, 32'd0, "R6 r0 still zero"); adv();
  endtask

  task automatic t_mem();
    at(9, "R5 pc");
    chk(st_en_o === 1'b1 && st_addr_o === 32'd8 && st_data_o === 32'd5, "R5 store", st_data_o, 32'd5);
    adv();
    wb(9, 32'd5, "R5 load back"); adv();
  endtask

  task automatic t_build_target();
    wb(10, 32'h4000, "R4 addi 0x4000"); adv();
    for (int k = 1; k <= 8; k++) begin
      wb(10, 32'h4000 << k, "R3 doubling"); adv();
    end
    at(20, "R2 pc"); wb(11, 32'h0040_0078, "R4 target in r11"); adv();
  endtask

  task automatic t_regjump();
    at(21, "R9 pc"); nowb("R10 no write on compare-jump"); adv();
    at(30, "R9 taken 5<6"); nowb("R10 no write"); adv();
    at(31, "R9 not taken 5<5"); adv();
    at(32, "R9 not taken -3<-4"); wb(13, 32'h0040_00A0, "R4 target in r13"); adv();
    at(33, "R2 pc"); adv();
    at(40, "R9 taken -3<-2");
  endtask

  task automatic t_branch_jump();
    adv(); at(41, "R7 beq not taken");
    adv(); at(44, "R7 beq taken");
    adv(); at(47, "R8 jump"); wb(14, 32'd0, "R3 slt false"); adv();
    at(48, "R12 pc"); nowb("R12 undefined opcode writes nothing"); adv();
    at(49, "R12 followed by pc+4"); adv();
    at(49, "R8 jump to self"); adv();
    at(49, "R8 stays");
    chk(marker_hit == 1'b0, "R9 skipped words never executed", {31'b0, marker_hit}, 32'd0);
  endtask

  initial begin
    t_load_and_reset();
    t_alu();
    t_mem();
    t_build_target();
    t_regjump();
    t_branch_jump();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %h expected %h", 32'd0, 32'd1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule